// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a three-wire serial nonvolatile memory: a chip-select, a serial clock and a serial data input arrive from a host, and a serial data output with its own output-enable goes back. Behind the serial port sits a 1024-word by 16-bit array held in flip-flops. The host frames each command with chip-select. It reads words (one or a running stream), writes or erases a single word, fills or blanks the whole array, and opens or closes the write path. A program-enable input gates every array change as well.

All serial inputs are sampled in the system clock domain and their edges are detected there. A store starts when chip-select falls after a complete modifying command. It then runs for a parameter number of system clocks with no serial clock needed. While the store is pending, raising chip-select shows a ready/busy flag on the data output. A 1 shifted in by the host removes that flag from the line.

Top module: `serial_eeprom`

## Requirements
- R1: After reset the output-enable is low, the write path is closed, and every word of the array reads as 0xFFFF.
- R2: A command starts at the first serial-clock rise, with chip-select high, that samples a 1 on the data input. Earlier 0 bits are ignored. A 2-bit opcode follows, then a 10-bit address, then, for single write and fill-all, 16 data bits. Every field is sent MSB first.
- R3: Opcode 10 reads. After the last address bit the output is enabled and drives one 0 bit. On each later serial-clock rise it presents the next bit of the addressed word, MSB first.
- R4: If the serial clock keeps running after a read word, the following address comes out directly, with no 0 bit in front. Address 1023 is followed by address 0.
- R5: Opcode 01 writes the data bits to the addressed word when chip-select falls. An earlier value is replaced without an erase first.
- R6: Opcode 11 sets the addressed word to 0xFFFF when chip-select falls.
- R7: Opcode 00 takes its meaning from address bits 9:8. 11 opens the write path, 00 closes it, 10 sets every word to 0xFFFF, and 01 writes the 16 data bits into every word. Address bits 7:0 are ignored.
- R8: A write, erase, fill-all or blank-all changes the array only if program-enable is 1 when chip-select falls and the write path is open. Opening and closing the write path work whatever the level of program-enable.
- R9: After an accepted store, whenever chip-select is high and no read is in progress, the output is enabled. It drives 0 while the store cycle is running and 1 once it has finished.
- R10: A 1 sampled on a serial-clock rise while the status is shown turns the output-enable off at the next serial-clock fall, and not earlier.
- R11: Commands that start while a store cycle is running have no effect.
- R12: If chip-select falls before a command is complete, nothing is stored and no store cycle starts.
- R13: Outside read data and status, and whenever chip-select is low, the output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| csel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdin_i | input | 1 | Serial data input |
| prog_en_i | input | 1 | Program enable, required for array changes |
| sdout_o | output | 1 | Serial data output |
| sdout_oe_o | output | 1 | Output enable for the serial data line |

## Verification
The hardest case to reach is a command that arrives while a store cycle is still running. The bench sets a store time longer than a whole 29-bit write command, then sends a second write straight after the chip-select fall of the first. It later reads both words back in one running read to show that only the first one landed. The wrap from the last address to address 0 is reached the same way: both end words are written first, and a running read starts two words before the end.

// File: rtl/seep_pkg.sv
package seep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } seq_t;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_WRITE, K_ERASE, K_WREN, K_WRDIS, K_ERALL, K_WRALL
  } kind_t;

  // opcode plus the two top address bits select the command
  function automatic kind_t decode_cmd(input logic [1:0] op, input logic [1:0] top);
    kind_t k;
    case (op)
      2'b10:   k = K_READ;
      2'b01:   k = K_WRITE;
      2'b11:   k = K_ERASE;
      default: begin
        case (top)
          2'b11:   k = K_WREN;
          2'b00:   k = K_WRDIS;
          2'b10:   k = K_ERALL;
          default: k = K_WRALL;
        endcase
      end
    endcase
    return k;
  endfunction

  function automatic logic needs_data(input kind_t k);
    return (k == K_WRITE) || (k == K_WRALL);
  endfunction

  function automatic logic is_modify(input kind_t k);
    return (k == K_WRITE) || (k == K_ERASE) || (k == K_ERALL) || (k == K_WRALL);
  endfunction

  function automatic logic is_blank(input kind_t k);
    return (k == K_ERASE) || (k == K_ERALL);
  endfunction

endpackage

// File: rtl/seep_sync.sv
module seep_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic csel_i,
  input  logic sclk_i,
  input  logic sdin_i,
  input  logic prog_en_i,
  output logic cs_s,
  output logic di_s,
  output logic pe_s,
  output logic sk_rise,
  output logic sk_fall,
  output logic cs_fall
);
  logic [3:0] q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= '0;
      q2 <= '0;
    end else begin
      q1 <= {csel_i, sclk_i, sdin_i, prog_en_i};
      q2 <= q1;
    end
  end

  assign cs_s    = q1[3];
  assign di_s    = q1[1];
  assign pe_s    = q1[0];
  assign sk_rise = q1[2] & ~q2[2];
  assign sk_fall = ~q1[2] & q2[2];
  assign cs_fall = ~q1[3] & q2[3];
endmodule

// File: rtl/seep_array.sv
module seep_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_go) begin
      if (wr_all) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= wr_data;
      end else begin
        mem[wr_addr] <= wr_data;
      end
    end
  end

  assign rd_word = mem[rd_addr];

  // R6 / R7: a whole-array store reaches the first and last word
  assert_fill_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_all) |=> (mem[0] == $past(wr_data) && mem[DEPTH-1] == $past(wr_data)));
endmodule

// File: rtl/seep_ctrl.sv
module seep_ctrl
  import seep_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              di_s,
  input  logic              pe_s,
  input  logic              sk_rise,
  input  logic              sk_fall,
  input  logic              cs_fall,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_go,
  output logic              wr_all,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdout_o,
  output logic              sdout_oe_o
);
  localparam int MAXF  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CW    = $clog2(MAXF + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);

  seq_t              state;
  kind_t             kind;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] raddr;
  logic [BIT_W-1:0]  bidx;
  logic              wen, armed, clr_pend, do_q, oe_q, dout_q;
  logic [BW-1:0]     busy_cnt;

  // named internal events
  logic              busy, rd_step, addr_last, rd_enter, en_evt;
  logic [ADDR_W-1:0] addr_full;
  kind_t             kind_n;

  assign busy      = (busy_cnt != '0);
  assign addr_full = {addr[ADDR_W-2:0], di_s};
  assign kind_n    = decode_cmd(op, addr_full[ADDR_W-1 -: 2]);
  assign addr_last = cs_s && sk_rise && (state == ST_ADDR) && (cnt == CW'(ADDR_W - 1));
  assign rd_enter  = addr_last && (kind_n == K_READ);
  assign en_evt    = addr_last && (kind_n == K_WREN);
  assign rd_step   = cs_s && sk_rise && (state == ST_READ);
  assign wr_go     = cs_fall && (state == ST_DONE) && is_modify(kind) && pe_s && wen;

  assign wr_all  = (kind == K_ERALL) || (kind == K_WRALL);
  assign wr_addr = addr;
  assign wr_data = is_blank(kind) ? '1 : data;
  assign rd_addr = raddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; kind <= K_NONE; op <= '0; addr <= '0; data <= '0;
      cnt <= '0; raddr <= '0; bidx <= '0; wen <= 1'b0; armed <= 1'b0;
      clr_pend <= 1'b0; do_q <= 1'b0; busy_cnt <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (wr_go) begin
        busy_cnt <= BW'(BUSY_CYCLES);
        armed    <= 1'b1;
      end
      if (!cs_s) begin
        state    <= ST_IDLE;
        clr_pend <= 1'b0;
      end else begin
        if (sk_rise) begin
          if (armed && di_s) clr_pend <= 1'b1;
          case (state)
            ST_IDLE: if (di_s && !busy) begin
              state <= ST_OPC;
              cnt   <= '0;
            end
            ST_OPC: begin
              op  <= {op[0], di_s};
              cnt <= cnt + 1'b1;
              if (cnt == CW'(1)) begin
                state <= ST_ADDR;
                cnt   <= '0;
              end
            end
            ST_ADDR: begin
              addr <= addr_full;
              cnt  <= cnt + 1'b1;
              if (addr_last) begin
                kind <= kind_n;
                cnt  <= '0;
                if (kind_n == K_READ) begin
                  state <= ST_READ;
                  raddr <= addr_full;
                  bidx  <= BIT_W'(DATA_W - 1);
                  do_q  <= 1'b0;
                end else if (needs_data(kind_n)) begin
                  state <= ST_DATA;
                end else begin
                  state <= ST_DONE;
                  if (kind_n == K_WREN)  wen <= 1'b1;
                  if (kind_n == K_WRDIS) wen <= 1'b0;
                end
              end
            end
            ST_DATA: begin
              data <= {data[DATA_W-2:0], di_s};
              cnt  <= cnt + 1'b1;
              if (cnt == CW'(DATA_W - 1)) state <= ST_DONE;
            end
            ST_READ: begin
              do_q <= rd_word[bidx];
              bidx <= bidx - 1'b1;
              if (bidx == '0) raddr <= raddr + 1'b1;
            end
            default: ;
          endcase
        end
        if (sk_fall && clr_pend) begin
          armed    <= 1'b0;
          clr_pend <= 1'b0;
        end
      end
    end
  end

  // registered pin drivers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      oe_q   <= cs_s && ((state == ST_READ) || armed);
      dout_q <= (state == ST_READ) ? do_q : !busy;
    end
  end

  assign sdout_o    = dout_q;
  assign sdout_oe_o = oe_q;

  // R13: a deselected device releases the line
  assert_hiz_deselect_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sdout_oe_o);
  // R3: a read opens with a zero bit
  assert_read_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_enter |=> (state == ST_READ && !do_q));
  // R4: sequential read wraps from the top address to zero
  assert_read_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && raddr == '1 && bidx == '0) |=> (raddr == '0));
  // R8: the write path only opens through its command
  assert_wen_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> $past(en_evt));
  // R11: nothing reconfigures the device during a store cycle
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wen));
  // R9: status reads low while the store cycle still has time left
  assert_status_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cs_s && state != ST_READ && busy_cnt > BW'(1)) |=> !sdout_o);
endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csel_i,
  input  logic sclk_i,
  input  logic sdin_i,
  input  logic prog_en_i,
  output logic sdout_o,
  output logic sdout_oe_o
);
  logic cs_s, di_s, pe_s, sk_rise, sk_fall, cs_fall;
  logic wr_go, wr_all;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_word;

  seep_sync u_sync (
    .clk(clk), .rst_n(rst_n), .csel_i(csel_i), .sclk_i(sclk_i),
    .sdin_i(sdin_i), .prog_en_i(prog_en_i), .cs_s(cs_s), .di_s(di_s),
    .pe_s(pe_s), .sk_rise(sk_rise), .sk_fall(sk_fall), .cs_fall(cs_fall)
  );

  seep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .di_s(di_s), .pe_s(pe_s),
    .sk_rise(sk_rise), .sk_fall(sk_fall), .cs_fall(cs_fall), .rd_word(rd_word),
    .rd_addr(rd_addr), .wr_go(wr_go), .wr_all(wr_all), .wr_addr(wr_addr),
    .wr_data(wr_data), .sdout_o(sdout_o), .sdout_oe_o(sdout_oe_o)
  );

  seep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_all(wr_all),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_word(rd_word)
  );
endmodule

// File: tb/serial_eeprom_tb_top.sv
module serial_eeprom_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 400;
  localparam int HALF       = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csel = 1'b0, sclk = 1'b0, sdin = 1'b0, pe = 1'b1;
  logic sdout, sdout_oe;

  int vec = 0, miss = 0, cyc = 0;
  int busy_until = -1000;
  int pend = 0;               // 0 none, 1 write, 2 erase, 3 blank all, 4 fill all
  logic [9:0]  pend_addr;
  logic [15:0] pend_data;
  logic        m_wen = 1'b0;
  logic [15:0] m [1024];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  serial_eeprom #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .csel_i(csel), .sclk_i(sclk), .sdin_i(sdin),
    .prog_en_i(pe), .sdout_o(sdout), .sdout_oe_o(sdout_oe)
  );

  initial begin
    #(CLK_PERIOD * 150000);
    miss++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    sdin = b; sclk = 1'b0; step(HALF);
    sclk = 1'b1; step(HALF);
  endtask

  // reference: send a command, decode it the model's way
  task automatic send(input logic [1:0] op, input logic [9:0] a, input logic [15:0] d,
                      input int lead);
    int start;
    bit ign, hasd;
    csel = 1'b1; step(HALF);
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    start = cyc;
    sk_bit(1'b1);
    for (int i = 1; i >= 0; i--) sk_bit(op[i]);
    for (int i = 9; i >= 0; i--) sk_bit(a[i]);
    hasd = (op == 2'b01) || (op == 2'b00 && a[9:8] == 2'b01);
    if (hasd) for (int i = 15; i >= 0; i--) sk_bit(d[i]);
    ign = (start < busy_until + 8);
    pend = 0;
    if (!ign) begin
      case (op)
        2'b01: pend = 1;
        2'b11: pend = 2;
        2'b00: case (a[9:8])
          2'b11: m_wen = 1'b1;
          2'b00: m_wen = 1'b0;
          2'b10: pend = 3;
          default: pend = 4;
        endcase
        default: pend = 0;
      endcase
    end
    pend_addr = a; pend_data = d;
  endtask

  task automatic end_cmd();
    sclk = 1'b0; csel = 1'b0; step(HALF);
    if (pend != 0 && pe && m_wen) begin
      case (pend)
        1: m[pend_addr] = pend_data;
        2: m[pend_addr] = 16'hFFFF;
        3: for (int i = 0; i < 1024; i++) m[i] = 16'hFFFF;
        default: for (int i = 0; i < 1024; i++) m[i] = pend_data;
      endcase
      busy_until = cyc + BUSY;
    end
    pend = 0;
  endtask

  task automatic read_chk(input logic [9:0] a, input int n, input int lead, input string tag);
    send(2'b10, a, 16'h0, lead);
    check({tag, " dummy oe"}, int'(sdout_oe), 1);
    check({tag, " dummy zero"}, int'(sdout), 0);
    for (int w = 0; w < n; w++) begin
      for (int b = 15; b >= 0; b--) begin
        sk_bit(1'b0);
        check({tag, " data bit"}, int'(sdout), int'(m[(int'(a) + w) % 1024][b]));
      end
    end
    end_cmd();
    check({tag, " release"}, int'(sdout_oe), 0);
  endtask

  task automatic wait_ready();
    step(BUSY + 20);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) m[i] = 16'hFFFF;
    step(3); rst_n = 1'b1; step(3);

    // R1: reset state
    check("R1 oe after reset", int'(sdout_oe), 0);
    read_chk(10'd5, 1, 0, "R1 R3 blank read");

    // R8: closed write path blocks a write
    send(2'b01, 10'd5, 16'h1234, 0);
    end_cmd();
    csel = 1'b1; step(HALF);
    check("R8 no status when closed", int'(sdout_oe), 0);
    end_cmd();
    read_chk(10'd5, 1, 0, "R8 closed path");

    // R7 R8: open with program-enable low, then a write with pe low is refused
    pe = 1'b0;
    send(2'b00, 10'b11_0101_0101, 16'h0, 0); end_cmd();
    send(2'b01, 10'd5, 16'h4321, 0); end_cmd();
    read_chk(10'd5, 1, 0, "R8 pe low");
    pe = 1'b1;

    // R5 R9 R10: accepted write, status busy then ready, dummy 1 clears
    send(2'b01, 10'd5, 16'hA5C3, 0); end_cmd();
    csel = 1'b1; step(HALF);
    check("R9 status oe", int'(sdout_oe), 1);
    check("R9 busy low", int'(sdout), 0);
    wait_ready();
    check("R9 ready high", int'(sdout), 1);
    sk_bit(1'b1);
    check("R10 still shown before fall", int'(sdout_oe), 1);
    sclk = 1'b0; step(HALF);
    check("R10 released after fall", int'(sdout_oe), 0);
    end_cmd();
    read_chk(10'd5, 1, 0, "R5 write");

    // R11 R13: a write, then a second write while busy
    send(2'b01, 10'd6, 16'h1111, 0);
    check("R13 hi-z during command", int'(sdout_oe), 0);
    end_cmd();
    send(2'b01, 10'd7, 16'h2222, 0); end_cmd();
    wait_ready();
    read_chk(10'd5, 3, 0, "R11 busy ignore");

    // R5: overwrite without erase; R2: leading zeros
    send(2'b01, 10'd5, 16'h0F0F, 0); end_cmd(); wait_ready();
    read_chk(10'd5, 1, 3, "R2 R5 overwrite");

    // R4: running read across the wrap
    send(2'b01, 10'd1023, 16'hBEEF, 0); end_cmd(); wait_ready();
    send(2'b01, 10'd0, 16'h1357, 0); end_cmd(); wait_ready();
    read_chk(10'd1022, 3, 0, "R4 wrap");

    // R6: single erase
    send(2'b11, 10'd6, 16'h0, 0); end_cmd(); wait_ready();
    read_chk(10'd6, 1, 0, "R6 erase");

    // R12: aborted write
    csel = 1'b1; step(HALF);
    sk_bit(1'b1); sk_bit(1'b0); sk_bit(1'b1);
    for (int i = 0; i < 5; i++) sk_bit(1'b0);
    sclk = 1'b0; csel = 1'b0; step(HALF);
    csel = 1'b1; step(HALF);
    check("R12 no status after abort", int'(sdout_oe), 0);
    end_cmd();
    read_chk(10'd0, 1, 0, "R12 abort");

    // R7: fill all, then blank all
    send(2'b00, 10'b01_1010_1010, 16'h2468, 0); end_cmd(); wait_ready();
    read_chk(10'd1021, 4, 0, "R7 fill all");
    send(2'b00, 10'b10_0000_1111, 16'h0, 0); end_cmd(); wait_ready();
    read_chk(10'd300, 2, 0, "R7 blank all");

    // R7 R8: close the path, write refused
    send(2'b00, 10'b00_1111_0000, 16'h0, 0); end_cmd();
    send(2'b01, 10'd9, 16'h5555, 0); end_cmd();
    csel = 1'b1; step(HALF);
    check("R8 no status after close", int'(sdout_oe), 0);
    end_cmd();
    read_chk(10'd9, 1, 0, "R7 closed again");

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule